// File: doc/BRIEF.md
# Translation Buffer Insert and Lookup

A fully associative translation buffer of 64 entries, each holding a 64-bit tag and a 64-bit translation word. Bit 63 of a translation word marks the entry valid and bit 6 marks it locked. Software-style requests arrive on a single valid/ready port carrying an operation code, an address and write data. The port is always ready and takes one request per cycle.

A staging register (the tag-access register, register index 6 in the buffer's register space, selected by address bits [6:3]) is written first. The next insert or indexed write uses its value as the tag. An insert lets the hardware pick the victim. It takes the lowest-index invalid entry, else the lowest-index unlocked entry. When every entry is both valid and locked, the insert is dropped and a sticky failure flag is raised. An indexed write names the entry in address bits [8:3]. A tag search returns the tag and index of the lowest-index valid entry whose tag equals the write data. Both the victim search and the tag search finish in one cycle through priority encoders. Read responses come out registered, one cycle after the request.

Top module: `xbuf_tlb`

## Requirements
- R1: After reset, every entry is invalid, the tag-access register is zero, `rsp_valid_o` is low and `insert_fail_o` is low.
- R2: Op code 0 (register write) with address bits [6:3] equal to 6 loads `req_wdata_i` into the tag-access register. Op code 1 (register read) returns it one cycle later. Writes to any other register index are ignored, and reads of them return zero.
- R3: Op code 2 (insert) writes the tag-access value as tag and `req_wdata_i` as translation word into the lowest-index entry whose bit 63 is clear.
- R4: If no entry is invalid, an insert replaces the lowest-index entry whose bit 6 is clear. A locked entry is never replaced.
- R5: If all entries are valid and locked, an insert changes no entry and sets `insert_fail_o`. The flag then stays high until reset.
- R6: Op code 3 (indexed write) writes the tag-access value and `req_wdata_i` into the entry numbered by address bits [8:3]. Other address bits are ignored. A word with bit 63 clear makes that entry invalid.
- R7: Op code 4 (tag search) compares `req_wdata_i` against the tags. One cycle later it returns `rsp_valid_o`=1 with `rsp_hit_o`=1, the matching tag and the index of the lowest-index valid entry whose tag matches.
- R8: A tag search with no valid matching entry returns `rsp_hit_o`=0, data 0 and index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_op_i | input | 3 | Operation code |
| req_addr_i | input | 64 | Register index [6:3] or entry index [8:3] |
| req_wdata_i | input | 64 | Write data or search key |
| rsp_valid_o | output | 1 | Read response present |
| rsp_data_o | output | 64 | Register value or matched tag |
| rsp_hit_o | output | 1 | Tag search found a match |
| rsp_idx_o | output | 6 | Index of matched entry |
| insert_fail_o | output | 1 | Sticky: an insert found no victim |

## Verification
The assertions assume that `req_op_i` carries only codes 0 to 4 while `req_valid_i` is high, and that a request is held for exactly one cycle. The bench drives each request for one clock and draws op codes only from that set.

Random tag keys come from a small pool, so searches hit duplicates and misses alike. Random lock bits let the buffer fill with locked entries, which exercises the fallback and failure paths. Directed sequences cover an all-locked buffer, duplicate tags and index 63.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  typedef enum logic [2:0] {
    OP_REG_WR  = 3'd0,
    OP_REG_RD  = 3'd1,
    OP_INSERT  = 3'd2,
    OP_DATA_WR = 3'd3,
    OP_TAG_RD  = 3'd4
  } xbuf_op_e;
endpackage

// File: rtl/xbuf_prio_enc.sv
module xbuf_prio_enc #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xbuf_victim.sv
module xbuf_victim #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  valid_i,
  input  logic [N-1:0]  lock_i,
  output logic          ok_o,
  output logic [IW-1:0] idx_o
);
  logic          inv_found, unl_found;
  logic [IW-1:0] inv_idx, unl_idx;

  xbuf_prio_enc #(.N(N), .IW(IW)) u_inv (
    .req_i(~valid_i), .found_o(inv_found), .idx_o(inv_idx));
  xbuf_prio_enc #(.N(N), .IW(IW)) u_unl (
    .req_i(~lock_i), .found_o(unl_found), .idx_o(unl_idx));

  assign ok_o  = inv_found | unl_found;
  assign idx_o = inv_found ? inv_idx : unl_idx;
endmodule

// File: rtl/xbuf_match.sv
module xbuf_match #(
  parameter int N     = 64,
  parameter int TAG_W = 64,
  parameter int IW    = $clog2(N)
) (
  input  logic [N-1:0][TAG_W-1:0] tags_i,
  input  logic [N-1:0]            valid_i,
  input  logic [TAG_W-1:0]        key_i,
  output logic                    hit_o,
  output logic [IW-1:0]           idx_o,
  output logic [TAG_W-1:0]        tag_o
);
  logic [N-1:0] hit_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] && (tags_i[g] == key_i);
  end

  xbuf_prio_enc #(.N(N), .IW(IW)) u_enc (
    .req_i(hit_vec), .found_o(hit_o), .idx_o(idx_o));

  assign tag_o = hit_o ? tags_i[idx_o] : '0;
endmodule

// File: rtl/xbuf_tlb.sv
module xbuf_tlb
  import xbuf_pkg::*;
#(
  parameter int N           = 64,
  parameter int TAG_W       = 64,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 64,
  parameter int VALID_BIT   = 63,
  parameter int LOCK_BIT    = 6,
  parameter int REG_TAG_ACC = 6,
  localparam int IW         = $clog2(N),
  localparam int REG_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_data_o,
  output logic              rsp_hit_o,
  output logic [IW-1:0]     rsp_idx_o,
  output logic              insert_fail_o
);
  logic [N-1:0][TAG_W-1:0]  tag_q;
  logic [N-1:0][DATA_W-1:0] tte_q;
  logic [TAG_W-1:0]         acc_q;
  logic [N-1:0]             valid_v, lock_v;
  logic                     vict_ok, m_hit;
  logic [IW-1:0]            vict_idx, m_idx, wr_idx;
  logic [TAG_W-1:0]         m_tag;
  logic [REG_W-1:0]         reg_sel;
  logic                     is_ins, is_dwr, is_rrd, is_trd, is_rwr;

  for (genvar g = 0; g < N; g++) begin : g_bits
    assign valid_v[g] = tte_q[g][VALID_BIT];
    assign lock_v[g]  = tte_q[g][LOCK_BIT];
  end

  assign req_ready_o = 1'b1;
  assign reg_sel = req_addr_i[3+:REG_W];
  assign wr_idx  = req_addr_i[3+:IW];
  assign is_rwr  = req_valid_i && (req_op_i == OP_REG_WR);
  assign is_rrd  = req_valid_i && (req_op_i == OP_REG_RD);
  assign is_ins  = req_valid_i && (req_op_i == OP_INSERT);
  assign is_dwr  = req_valid_i && (req_op_i == OP_DATA_WR);
  assign is_trd  = req_valid_i && (req_op_i == OP_TAG_RD);

  xbuf_victim #(.N(N), .IW(IW)) u_victim (
    .valid_i(valid_v), .lock_i(lock_v), .ok_o(vict_ok), .idx_o(vict_idx));

  xbuf_match #(.N(N), .TAG_W(TAG_W), .IW(IW)) u_match (
    .tags_i(tag_q), .valid_i(valid_v), .key_i(TAG_W'(req_wdata_i)),
    .hit_o(m_hit), .idx_o(m_idx), .tag_o(m_tag));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q         <= '0;
      tte_q         <= '0;
      acc_q         <= '0;
      insert_fail_o <= 1'b0;
    end else begin
      if (is_rwr && reg_sel == REG_W'(REG_TAG_ACC)) acc_q <= TAG_W'(req_wdata_i);
      if (is_dwr) begin
        tag_q[wr_idx] <= acc_q;
        tte_q[wr_idx] <= req_wdata_i;
      end
      if (is_ins) begin
        if (vict_ok) begin
          tag_q[vict_idx] <= acc_q;
          tte_q[vict_idx] <= req_wdata_i;
        end else begin
          insert_fail_o <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= is_rrd || is_trd;
      rsp_data_o  <= '0;
      rsp_hit_o   <= 1'b0;
      rsp_idx_o   <= '0;
      if (is_rrd && reg_sel == REG_W'(REG_TAG_ACC)) rsp_data_o <= acc_q;
      if (is_trd) begin
        rsp_data_o <= m_tag;
        rsp_hit_o  <= m_hit;
        rsp_idx_o  <= m_idx;
      end
    end
  end

  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insert_fail_o |=> insert_fail_o); // R5
  AST_FAIL_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ins && (&valid_v) && (&lock_v)) |=> insert_fail_o); // R5
  AST_FULL_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ins && (&valid_v) && (&lock_v)) |=> $stable(tte_q)); // R5
  AST_NO_LOCKED_VICTIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ins && vict_ok && (&valid_v)) |-> !lock_v[vict_idx]); // R4
  AST_INVALID_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ins && !(&valid_v)) |-> !valid_v[vict_idx]); // R3
  AST_SEARCH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_trd |=> rsp_valid_o); // R7
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_data_o == '0 || $past(is_rrd))); // R8
endmodule

// File: tb/xbuf_tlb_tb_top.sv
module xbuf_tlb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [2:0]  req_op_i = '0;
  logic [63:0] req_addr_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic        rsp_valid_o;
  logic [63:0] rsp_data_o;
  logic        rsp_hit_o;
  logic [5:0]  rsp_idx_o;
  logic        insert_fail_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_tag [N];
  logic [63:0] m_tte [N];
  logic [63:0] m_acc;
  logic        m_fail;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xbuf_tlb dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i,
    .req_wdata_i, .rsp_valid_o, .rsp_data_o, .rsp_hit_o, .rsp_idx_o,
    .insert_fail_o);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    m_acc = '0; m_fail = 1'b0;
  endtask

  // drive one request; returns at the next falling edge, response visible
  task automatic op(input logic [2:0] code, input logic [63:0] addr, input logic [63:0] wd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_op_i = code; req_addr_i = addr; req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    case (code)
      3'd0: if (addr[6:3] == 4'd6) m_acc = wd;
      3'd2: model_insert(wd);
      3'd3: begin m_tag[addr[8:3]] = m_acc; m_tte[addr[8:3]] = wd; end
      default: ;
    endcase
  endtask

  task automatic model_insert(input logic [63:0] wd);
    int v = -1;
    for (int i = 0; i < N; i++) if (v < 0 && !m_tte[i][63]) v = i;
    for (int i = 0; i < N; i++) if (v < 0 && !m_tte[i][6]) v = i;
    if (v < 0) m_fail = 1'b1;
    else begin m_tag[v] = m_acc; m_tte[v] = wd; end
  endtask

  task automatic search(input string req, input logic [63:0] key);
    int v = -1;
    op(3'd4, 64'h0, key);
    for (int i = 0; i < N; i++) if (v < 0 && m_tte[i][63] && m_tag[i] == key) v = i;
    chk(req, "search rsp_valid", 64'(rsp_valid_o), 64'd1);
    chk(req, "search hit", 64'(rsp_hit_o), 64'(v >= 0));
    chk(req, "search data", rsp_data_o, (v >= 0) ? m_tag[v] : 64'h0);
    chk(req, "search idx", 64'(rsp_idx_o), (v >= 0) ? 64'(v) : 64'h0);
  endtask

  task automatic set_acc(input logic [63:0] t);
    op(3'd0, 64'(6 << 3), t);
  endtask

  function automatic logic [63:0] tte(input bit vld, input bit lck, input logic [31:0] pay);
    logic [63:0] w = {32'h0, pay};
    w[63] = vld; w[6] = lck;
    return w;
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    do_reset();
    // R1: reset state
    chk("R1", "rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R1", "insert_fail", 64'(insert_fail_o), 64'd0);
    chk("R1", "ready", 64'(req_ready_o), 64'd1);
    search("R1", 64'h0);
    op(3'd1, 64'(6 << 3), 0);
    chk("R1", "tag-access zero", rsp_data_o, 64'h0);

    // R2: staging register
    set_acc(64'hDEAD_BEEF_0000_1111);
    op(3'd1, 64'(6 << 3), 0);
    chk("R2", "readback", rsp_data_o, 64'hDEAD_BEEF_0000_1111);
    op(3'd0, 64'(5 << 3), 64'h5555);
    op(3'd1, 64'(6 << 3), 0);
    chk("R2", "other index write ignored", rsp_data_o, 64'hDEAD_BEEF_0000_1111);
    op(3'd1, 64'(5 << 3), 0);
    chk("R2", "other index read zero", rsp_data_o, 64'h0);

    // R3: inserts fill lowest invalid
    for (int i = 0; i < 3; i++) begin
      set_acc(64'h100 + 64'(i));
      op(3'd2, 0, tte(1, 0, 32'(i)));
      search("R3", 64'h100 + 64'(i));
    end
    op(3'd3, 64'(1 << 3), tte(0, 0, 0));   // R6: invalidate entry 1
    search("R6", 64'h101);
    set_acc(64'h200);
    op(3'd2, 0, tte(1, 0, 7));
    search("R3", 64'h200);
    chk("R3", "reuse idx", 64'(rsp_idx_o), 64'd1);

    // R6: indexed write, upper address bits ignored
    set_acc(64'h3F3F);
    op(3'd3, 64'hFFFF_0000_0000_FE00 | 64'(63 << 3), tte(1, 0, 1));
    search("R6", 64'h3F3F);
    chk("R6", "idx 63", 64'(rsp_idx_o), 64'd63);

    // R7: duplicate tags -> lowest index
    set_acc(64'h777);
    op(3'd3, 64'(10 << 3), tte(1, 0, 0));
    op(3'd3, 64'(5 << 3), tte(1, 0, 0));
    search("R7", 64'h777);
    chk("R7", "lowest dup", 64'(rsp_idx_o), 64'd5);
    search("R8", 64'h9999);

    // R4: full buffer, all locked except 40 and 50
    for (int i = 0; i < N; i++) begin
      set_acc(64'h1000 + 64'(i));
      op(3'd3, 64'(i << 3), tte(1, (i != 40 && i != 50), 32'(i)));
    end
    set_acc(64'h4444);
    op(3'd2, 0, tte(1, 1, 0));
    search("R4", 64'h4444);
    chk("R4", "victim idx", 64'(rsp_idx_o), 64'd40);
    search("R4", 64'h1000 + 64'd40);
    chk("R4", "no fail yet", 64'(insert_fail_o), 64'd0);
    set_acc(64'h5555);
    op(3'd2, 0, tte(1, 1, 0));
    search("R4", 64'h5555);
    chk("R4", "second victim", 64'(rsp_idx_o), 64'd50);

    // R5: all locked -> dropped, sticky
    set_acc(64'h6666);
    op(3'd2, 0, tte(1, 0, 0));
    chk("R5", "fail set", 64'(insert_fail_o), 64'd1);
    search("R5", 64'h6666);
    search("R5", 64'h1000);
    op(3'd1, 64'(6 << 3), 0);
    chk("R5", "fail sticky", 64'(insert_fail_o), 64'd1);

    // R1: reset again clears everything
    do_reset();
    chk("R1", "fail cleared", 64'(insert_fail_o), 64'd0);
    search("R1", 64'h1000);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int k = $urandom_range(0, 9);
      logic [63:0] key = 64'hA500 + 64'($urandom_range(0, 11));
      logic [63:0] a = {$urandom, $urandom};
      if (k < 2) op(3'd0, (k == 0) ? ((a & ~64'h78) | 64'(6 << 3)) : a, key);
      else if (k < 5) op(3'd2, a, tte($urandom_range(0, 7) != 0, $urandom_range(0, 2) != 0, $urandom));
      else if (k < 6) op(3'd3, a, tte($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom));
      else if (k < 9) search("R7", key);
      else begin
        op(3'd1, a, 0);
        chk("R2", "random reg read", rsp_data_o, (a[6:3] == 4'd6) ? m_acc : 64'h0);
      end
      chk("R5", "fail flag", 64'(insert_fail_o), 64'(m_fail));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule